// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a memory device's boundary-scan logic. A sixteen-state controller is advanced by the test mode select line on each rising edge of the test clock. An eight-bit instruction register picks one of three data registers: a one-bit bypass stage, a 32-bit identification register, or a 104-cell boundary chain. The selected register is placed between the serial input and the serial output. The serial output and its enable change only on the falling test clock edge. Update latches in the instruction and boundary paths also act on the falling edge.

A strap input, `wide_cfg`, chooses the narrow (x16) or wide (x32) variant. The strap selects the identification code. In the narrow variant it also forces the cells of the unused pins, cells 88 through 103, to capture a logic 1. Each leg of a differential clock or strobe pair owns its own cell, so the chain treats every leg as a plain single-ended pin. On the pin side, `pin_in` feeds the capture stage and `pin_out` carries the update latch. `extest_mode` tells the pad logic to drive the pins from `pin_out`.

Controller states:
- Reset, Idle
- Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR
- Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR

Transitions, where a value of 1 or 0 is the TMS level at the rising edge:
- Reset goes to Idle on 0. Idle goes to Select-DR on 1.
- Select-DR goes to Select-IR on 1 and to Capture-DR on 0. Select-IR goes to Reset on 1 and to Capture-IR on 0.
- Capture goes to Shift on 0 and to Exit1 on 1. Shift stays in Shift on 0 and goes to Exit1 on 1.
- Exit1 goes to Update on 1 and to Pause on 0. Pause stays in Pause on 0 and goes to Exit2 on 1.
- Exit2 goes to Update on 1 and back to Shift on 0.
- Update goes to Select-DR on 1 and to Idle on 0.
- Any state not listed above holds on 0.

Top module: `scan_tap`

## Requirements
- R1: Five consecutive rising edges with `tms` high bring the controller to Reset from any state. Asserting `trst_n` low enters Reset at once and clears `pin_out` to all zeros.
- R2: In Reset the active instruction becomes IDCODE (0x21), so a data scan straight after reset returns the identification code.
- R3: Capture-IR loads 0b00000001 into the instruction shift stage. It is shifted out least significant bit first, so the first bit out during an instruction scan is 1 and the next seven are 0.
- R4: With code 0x21 active, Capture-DR loads 0x100A7083 when `wide_cfg`=0 and 0x200A7083 when `wide_cfg`=1. The value leaves bit 0 first, followed 32 bits later by the data shifted in.
- R5: With code 0xFF active, a single stage sits in the path. It captures 0, so the output is 0 followed by the input delayed by one shift.
- R6: Every code other than 0x00, 0x05, 0x21 and 0xFF acts as 0xFF: one-stage path, `extest_mode` low, `pin_out` untouched.
- R7: With code 0x05 active, Capture-DR loads `pin_in` into the 104-cell chain. Cell k takes `pin_in[k]`, and cell 0 is nearest the output. `extest_mode` stays low.
- R8: When `wide_cfg`=0, cells 88 through 103 capture 1 whatever `pin_in` holds there.
- R9: Under code 0x00 or 0x05, Update-DR copies the chain into `pin_out` on the falling edge. `extest_mode` is high exactly while code 0x00 is active. Data preloaded under 0x05 appears on `pin_out` once 0x00 is loaded.
- R10: Under any code other than 0x00 and 0x05, data scans leave `pin_out` unchanged.
- R11: `tdo_en` is high only during Shift-IR and Shift-DR. Both it and `tdo` change on the falling test clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| wide_cfg | input | 1 | Variant strap: 1 = x32, 0 = x16 |
| pin_in | input | 104 | Pin values presented to the capture cells |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for `tdo` |
| pin_out | output | 104 | Boundary update latch, drives pins in test mode |
| extest_mode | output | 1 | High while the external test instruction is active |

## Verification
A wrong controller state shows up on `tdo_en` at the next falling edge. Because every scan is a fixed sequence, it also shifts every later captured bit, and the first serial bit out is already wrong. A wrong instruction decode shows on the next data scan: the register length in the path changes, which moves the echoed input by a different number of shifts. The same scan also changes the captured header. A stale or mis-enabled update latch appears on `pin_out` right after the falling edge in Update-DR, or fails to appear there. Sweeping all 256 instruction codes under both straps exposes any code routed to the wrong register within one scan.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h05;
    localparam logic [IR_W-1:0] OP_IDCODE  = 8'h21;
    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_DR_SEL,
        TS_DR_CAP,
        TS_DR_SHIFT,
        TS_DR_EXIT1,
        TS_DR_PAUSE,
        TS_DR_EXIT2,
        TS_DR_UPD,
        TS_IR_SEL,
        TS_IR_CAP,
        TS_IR_SHIFT,
        TS_IR_EXIT1,
        TS_IR_PAUSE,
        TS_IR_EXIT2,
        TS_IR_UPD
    } tap_state_t;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_IDCODE,
        SEL_BOUNDARY
    } dr_sel_t;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr
);

    tap_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            TS_RESET:    state_nx = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_nx = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   state_nx = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   state_nx = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: state_nx = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: state_nx = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: state_nx = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: state_nx = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   state_nx = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   state_nx = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   state_nx = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: state_nx = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: state_nx = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: state_nx = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: state_nx = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   state_nx = tms ? TS_DR_SEL   : TS_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= state_nx;
    end

    always_comb begin
        in_reset = 1'b0;
        cap_ir   = 1'b0;
        sh_ir    = 1'b0;
        upd_ir   = 1'b0;
        cap_dr   = 1'b0;
        sh_dr    = 1'b0;
        upd_dr   = 1'b0;
        unique case (state)
            TS_RESET:    in_reset = 1'b1;
            TS_IR_CAP:   cap_ir   = 1'b1;
            TS_IR_SHIFT: sh_ir    = 1'b1;
            TS_IR_UPD:   upd_ir   = 1'b1;
            TS_DR_CAP:   cap_dr   = 1'b1;
            TS_DR_SHIFT: sh_dr    = 1'b1;
            TS_DR_UPD:   upd_dr   = 1'b1;
            TS_IDLE, TS_DR_SEL, TS_DR_EXIT1, TS_DR_PAUSE, TS_DR_EXIT2,
            TS_IR_SEL, TS_IR_EXIT1, TS_IR_PAUSE, TS_IR_EXIT2: ;
        endcase
    end

    logic [2:0] tms_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              tms_run <= 3'd0;
        else if (!tms)            tms_run <= 3'd0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    // R1
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    output logic            ir_lsb,
    output dr_sel_t         dr_sel,
    output logic            extest_mode
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     ir_sh <= '0;
        else if (cap_ir) ir_sh <= IR_CAPTURE;
        else if (sh_ir)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)       ir_q <= OP_IDCODE;
        else if (in_reset) ir_q <= OP_IDCODE;
        else if (upd_ir)   ir_q <= ir_sh;
    end

    always_comb begin
        unique case (ir_q)
            OP_EXTEST, OP_SAMPLE: dr_sel = SEL_BOUNDARY;
            OP_IDCODE:            dr_sel = SEL_IDCODE;
            default:              dr_sel = SEL_BYPASS;
        endcase
    end

    assign extest_mode = (ir_q == OP_EXTEST);
    assign ir_lsb      = ir_sh[0];

    // R3
    ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
        cap_ir |=> (ir_sh == IR_CAPTURE));

    // R2
    reset_selects_id_chk: assert property (@(negedge tck) disable iff (!trst_n)
        in_reset |=> (dr_sel == SEL_IDCODE && !extest_mode));

endmodule

// File: rtl/scan_tap_bsr.sv
module scan_tap_bsr #(
    parameter int CHAIN_LEN = 104,
    parameter int UNUSED_LO = 88,
    parameter int UNUSED_HI = 103
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  logic                 active,
    input  logic                 wide_cfg,
    input  logic                 cap_dr,
    input  logic                 sh_dr,
    input  logic                 upd_dr,
    input  logic [CHAIN_LEN-1:0] pin_in,
    output logic                 chain_lsb,
    output logic [CHAIN_LEN-1:0] pin_out
);

    logic [CHAIN_LEN-1:0] cap_val;
    logic [CHAIN_LEN-1:0] chain;
    logic [CHAIN_LEN-1:0] upd_q;

    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
        if (k >= UNUSED_LO && k <= UNUSED_HI) begin : g_spare
            assign cap_val[k] = wide_cfg ? pin_in[k] : 1'b1;
        end else begin : g_used
            assign cap_val[k] = pin_in[k];
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                chain <= '0;
        else if (active && cap_dr)  chain <= cap_val;
        else if (active && sh_dr)   chain <= {tdi, chain[CHAIN_LEN-1:1]};
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)               upd_q <= '0;
        else if (active && upd_dr) upd_q <= chain;
    end

    assign chain_lsb = chain[0];
    assign pin_out   = upd_q;

    // R8
    spare_cells_high_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (active && cap_dr && !wide_cfg) |=> (&chain[UNUSED_HI:UNUSED_LO]));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          CHAIN_LEN = 104,
    parameter int          UNUSED_LO = 88,
    parameter int          UNUSED_HI = 103,
    parameter int          ID_W      = 32,
    parameter logic [31:0] ID_NARROW = 32'h100A7083,
    parameter logic [31:0] ID_WIDE   = 32'h200A7083
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tms,
    input  logic                 tdi,
    input  logic                 wide_cfg,
    input  logic [CHAIN_LEN-1:0] pin_in,
    output logic                 tdo,
    output logic                 tdo_en,
    output logic [CHAIN_LEN-1:0] pin_out,
    output logic                 extest_mode
);

    tap_state_t state;
    logic       in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
    logic       ir_lsb, chain_lsb;
    dr_sel_t    dr_sel;

    scan_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr)
    );

    scan_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .ir_lsb(ir_lsb), .dr_sel(dr_sel), .extest_mode(extest_mode)
    );

    scan_tap_bsr #(
        .CHAIN_LEN(CHAIN_LEN), .UNUSED_LO(UNUSED_LO), .UNUSED_HI(UNUSED_HI)
    ) u_bsr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .active(dr_sel == SEL_BOUNDARY), .wide_cfg(wide_cfg),
        .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
        .pin_in(pin_in), .chain_lsb(chain_lsb), .pin_out(pin_out)
    );

    logic [ID_W-1:0] id_sh;
    logic            byp_q;
    logic            ser_bit;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sh <= '0;
            byp_q <= 1'b0;
        end else begin
            if (dr_sel == SEL_IDCODE && cap_dr)
                id_sh <= wide_cfg ? ID_WIDE : ID_NARROW;
            else if (dr_sel == SEL_IDCODE && sh_dr)
                id_sh <= {tdi, id_sh[ID_W-1:1]};
            if (dr_sel == SEL_BYPASS && cap_dr)
                byp_q <= 1'b0;
            else if (dr_sel == SEL_BYPASS && sh_dr)
                byp_q <= tdi;
        end
    end

    always_comb begin
        if (sh_ir) ser_bit = ir_lsb;
        else begin
            unique case (dr_sel)
                SEL_BOUNDARY: ser_bit = chain_lsb;
                SEL_IDCODE:   ser_bit = id_sh[0];
                default:      ser_bit = byp_q;
            endcase
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= ser_bit;
            tdo_en <= sh_ir | sh_dr;
        end
    end

    // R11
    tdo_en_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == TS_IR_SHIFT || state == TS_DR_SHIFT));

    // R10
    pins_held_chk: assert property (@(negedge tck) disable iff (!trst_n)
        (dr_sel != SEL_BOUNDARY) |=> $stable(pin_out));

    // R4
    id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_sel == SEL_IDCODE && cap_dr) |=>
            (id_sh == ($past(wide_cfg) ? ID_WIDE : ID_NARROW)));

endmodule

// File: tb/scan_tap_bench.sv
module scan_tap_bench;

    localparam int TCK_PERIOD = 20;
    localparam int NCELL      = 104;
    localparam int NSCAN      = 136;

    logic             tck = 1'b0;
    logic             trst_n, tms, tdi, wide_cfg;
    logic [NCELL-1:0] pin_in;
    logic             tdo, tdo_en, extest_mode;
    logic [NCELL-1:0] pin_out;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #(TCK_PERIOD/2) tck = ~tck;

    scan_tap u_scan_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .wide_cfg(wide_cfg),
        .pin_in(pin_in), .tdo(tdo), .tdo_en(tdo_en), .pin_out(pin_out),
        .extest_mode(extest_mode)
    );

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #(TCK_PERIOD/10);
        tms = m;
        tdi = d;
        #(TCK_PERIOD/5);
        o = tdo;
        e = tdo_en;
        @(posedge tck);
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [159:0] din,
                        output logic [159:0] dout, output logic en_ok);
        logic o, e;
        dout  = '0;
        en_ok = 1'b1;
        step(1'b1, 1'b0, o, e);
        if (is_ir) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            en_ok   = en_ok & e;
        end
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic load_ir(input logic [7:0] code);
        logic [159:0] d;
        logic         ok;
        scan(1'b1, 8, {152'd0, code}, d, ok);
        chk("R3 capture-IR pattern", d[7:0], 8'h01);
    endtask

    function automatic logic [159:0] mkpat(input int seed);
        logic [159:0] v;
        for (int i = 0; i < 160; i++)
            v[i] = (((i * 37 + seed * 11) >> 2) & 1) != ((i + seed) % 3 == 0);
        return v;
    endfunction

    function automatic logic [31:0] id_of(input logic w);
        return w ? 32'h200A7083 : 32'h100A7083;
    endfunction

    initial begin
        repeat (190000) @(posedge tck);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1 watchdog actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [159:0] din, dout, cap, exp;
        logic [NCELL-1:0] exp_pins;
        logic o, e, ok;
        int   len;
        string tag;

        trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; wide_cfg = 1'b0; pin_in = '0;
        #(3 * TCK_PERIOD);
        chk("R1 reset pin_out", {56'd0, pin_out}, 160'd0);
        chk("R11 reset tdo_en", {159'd0, tdo_en}, 160'd0);
        chk("R2 reset extest_mode", {159'd0, extest_mode}, 160'd0);
        trst_n = 1'b1;
        step(1'b0, 1'b0, o, e);
        scan(1'b0, 32, '0, dout, ok);
        chk("R2 id after reset", dout[31:0], id_of(1'b0));
        exp_pins = '0;

        // R4 R5 R6 R7 R8 R9 R10: all codes under both straps
        for (int cfg = 0; cfg < 2; cfg++) begin
            for (int code = 0; code < 256; code++) begin
                wide_cfg = cfg[0];
                pin_in   = mkpat(code * 7 + cfg + 500)[NCELL-1:0];
                din      = mkpat(code + cfg * 256);
                load_ir(code[7:0]);
                chk("R9 extest_mode", {159'd0, extest_mode}, {159'd0, code == 0});
                cap = '0;
                if (code == 0 || code == 5) begin
                    len = NCELL;
                    cap[NCELL-1:0] = pin_in;
                    if (cfg == 0) cap[103:88] = 16'hFFFF;
                    tag = (cfg == 0) ? "R8 narrow chain" : "R7 chain capture";
                end else if (code == 8'h21) begin
                    len = 32;
                    cap[31:0] = id_of(cfg[0]);
                    tag = "R4 id code";
                end else begin
                    len = 1;
                    tag = (code == 8'hFF) ? "R5 bypass" : "R6 reserved";
                end
                exp = '0;
                for (int i = 0; i < NSCAN; i++)
                    exp[i] = (i < len) ? cap[i] : din[i - len];
                scan(1'b0, NSCAN, din, dout, ok);
                chk(tag, dout, exp);
                chk("R11 tdo_en in shift", {159'd0, ok}, 160'd1);
                step(1'b0, 1'b0, o, e);
                chk("R11 tdo_en idle", {159'd0, e}, 160'd0);
                if (code == 0 || code == 5) begin
                    exp_pins = din[NSCAN-1:NSCAN-NCELL];
                    chk("R9 pin update", {56'd0, pin_out}, {56'd0, exp_pins});
                end else begin
                    chk("R10 pins held", {56'd0, pin_out}, {56'd0, exp_pins});
                end
            end
        end

        // R9 preload then external test
        wide_cfg = 1'b1;
        load_ir(8'h05);
        din = mkpat(9999);
        scan(1'b0, NSCAN, din, dout, ok);
        load_ir(8'h00);
        chk("R9 preload on pins", {56'd0, pin_out}, {56'd0, din[NSCAN-1:NSCAN-NCELL]});
        chk("R9 extest_mode high", {159'd0, extest_mode}, 160'd1);

        // R1 five tms-high edges
        load_ir(8'hFF);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        scan(1'b0, 32, '0, dout, ok);
        chk("R1 tms reset to id", dout[31:0], id_of(1'b1));

        // R1 asynchronous reset
        load_ir(8'hFF);
        #(TCK_PERIOD/3);
        trst_n = 1'b0;
        #(TCK_PERIOD/10);
        chk("R1 trst clears pins", {56'd0, pin_out}, 160'd0);
        tms = 1'b1;
        #(2 * TCK_PERIOD);
        trst_n = 1'b1;
        step(1'b0, 1'b0, o, e);
        scan(1'b0, 32, '0, dout, ok);
        chk("R2 id after trst", dout[31:0], id_of(1'b1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule